// File: doc/BRIEF.md
# Three-Bit Gray Sequence Counter

This block is a synchronous counter whose three state bits walk through the reflected Gray code. Each step changes exactly one bit. That makes the state safe to sample from another clock domain, and it keeps switching activity low. The bits are not produced by a binary incrementer followed by a converter. Each bit is its own JK-style stage, and its set and clear terms are decoded from the other two bits.

A synchronous reset returns the state to zero. An enable input advances the sequence by one position per rising clock edge, and the counter holds while enable is low. A second output gives the position of the current code word within the sequence as a plain binary number, for consumers that need an ordinal value.

Top module: `gray3_seq`

## Requirements
- R1: While `rstSync` is high at a rising edge, the next value of `grayState` is 000, and `seqIndex` then reads 000.
- R2: With `countEn` high and no reset, each rising edge moves `grayState` to the next code in the order 000, 001, 011, 010, 110, 111, 101, 100.
- R3: With `countEn` low and no reset, `grayState` keeps its value across the edge.
- R4: Every enabled step changes exactly one bit of `grayState`.
- R5: `seqIndex` is the position of `grayState` in the R2 order (000 is position 0, 100 is position 7), given by b2=g2, b1=b2^g1, b0=b1^g0.
- R6: The step from 100 goes to 000, so the sequence repeats.
- R7: Reset takes priority when `rstSync` and `countEn` are high together.
- R8: Eight enabled steps return `grayState` to its starting value, whatever disabled cycles are mixed in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every stage |
| rstSync | input | 1 | Synchronous reset, active high |
| countEn | input | 1 | Advance the sequence when high |
| grayState | output | 3 | Current Gray code word |
| seqIndex | output | 3 | Position of the current word, in binary |

## Verification
The checker watches three rules on every clocked cycle: an enabled step adds one to the index modulo eight, a disabled cycle leaves the code unchanged, and an enabled step flips exactly one bit. It also checks that the code is zero on the first cycle after reset is released. Only the bench scenarios can show the exact code word at each position, the wrap from 100 to 000, reset winning over enable, and the return to the starting word after eight enabled steps with idle cycles mixed in. The bench does this by comparing against its own reference counter and conversion.

// File: rtl/gray3_pkg.sv
package gray3_pkg;
  localparam int STATE_W = 3;
  localparam int SEQ_LEN = 1 << STATE_W;

  typedef struct packed {
    logic clear;
    logic step;
  } ctlStrobe_t;

  typedef logic [STATE_W-1:0] stateVec_t;
endpackage

// File: rtl/gray3_jk_stage.sv
module gray3_jk_stage (
  input  logic clk,
  input  logic clear,
  input  logic step,
  input  logic jIn,
  input  logic kIn,
  output logic qOut
);
  logic qNext;

  // JK stage: 00 hold, 01 clear, 10 set, 11 toggle.
  always_comb begin
    qNext = qOut;
    if (step) begin
      unique case ({jIn, kIn})
        2'b00: qNext = qOut;
        2'b01: qNext = 1'b0;
        2'b10: qNext = 1'b1;
        2'b11: qNext = ~qOut;
        default: qNext = qOut;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (clear) qOut <= 1'b0;
    else       qOut <= qNext;
  end
endmodule

// File: rtl/gray3_ctrl.sv
module gray3_ctrl
  import gray3_pkg::*;
(
  input  logic       rstSync,
  input  logic       countEn,
  output ctlStrobe_t strobes
);
  // Reset wins over enable.
  always_comb begin
    strobes.clear = rstSync;
    strobes.step  = countEn & ~rstSync;
  end
endmodule

// File: rtl/gray3_path.sv
module gray3_path
  import gray3_pkg::*;
(
  input  logic       clk,
  input  ctlStrobe_t strobes,
  output stateVec_t  grayState,
  output stateVec_t  seqIndex
);
  stateVec_t jVec;
  stateVec_t kVec;

  // Per-bit set/clear terms decoded from the other bits.
  always_comb begin
    jVec[2] = grayState[1] & ~grayState[0];
    kVec[2] = ~grayState[1] & ~grayState[0];
    jVec[1] = ~grayState[2] & grayState[0];
    kVec[1] = grayState[2] & grayState[0];
    jVec[0] = ~(grayState[2] ^ grayState[1]);
    kVec[0] = grayState[2] ^ grayState[1];
  end

  for (genvar i = 0; i < STATE_W; i++) begin : g_stage
    gray3_jk_stage u_stage (
      .clk   (clk),
      .clear (strobes.clear),
      .step  (strobes.step),
      .jIn   (jVec[i]),
      .kIn   (kVec[i]),
      .qOut  (grayState[i])
    );
  end

  // Prefix XOR from the top bit down gives the sequence position.
  always_comb begin
    seqIndex[STATE_W-1] = grayState[STATE_W-1];
    for (int i = STATE_W - 2; i >= 0; i--) begin
      seqIndex[i] = seqIndex[i+1] ^ grayState[i];
    end
  end
endmodule

// File: rtl/gray3_seq.sv
module gray3_seq
  import gray3_pkg::*;
(
  input  logic       clk,
  input  logic       rstSync,
  input  logic       countEn,
  output logic [2:0] grayState,
  output logic [2:0] seqIndex
);
  ctlStrobe_t strobes;

  gray3_ctrl u_ctrl (
    .rstSync (rstSync),
    .countEn (countEn),
    .strobes (strobes)
  );

  gray3_path u_path (
    .clk       (clk),
    .strobes   (strobes),
    .grayState (grayState),
    .seqIndex  (seqIndex)
  );
endmodule

// File: rtl/gray3_seq_chk.sv
module gray3_seq_chk (
  input logic       clk,
  input logic       rstSync,
  input logic       countEn,
  input logic [2:0] grayState,
  input logic [2:0] seqIndex
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rstSync)
    $fell(rstSync) |-> (grayState == 3'b000));

  // R2
  index_step_chk: assert property (@(posedge clk) disable iff (rstSync)
    countEn |=> (seqIndex == 3'($past(seqIndex) + 3'd1)));

  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (rstSync)
    !countEn |=> $stable(grayState));

  // R4
  one_bit_chk: assert property (@(posedge clk) disable iff (rstSync)
    countEn |=> ($countones(grayState ^ $past(grayState)) == 1));
endmodule

bind gray3_seq gray3_seq_chk u_chk (
  .clk       (clk),
  .rstSync   (rstSync),
  .countEn   (countEn),
  .grayState (grayState),
  .seqIndex  (seqIndex)
);

// File: tb/sim_gray3_seq.sv
module sim_gray3_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstSync = 1'b1;
  logic       countEn = 1'b0;
  logic [2:0] grayState;
  logic [2:0] seqIndex;

  int checks = 0;
  int errors = 0;
  logic [2:0] refIdx = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gray3_seq u0 (
    .clk       (clk),
    .rstSync   (rstSync),
    .countEn   (countEn),
    .grayState (grayState),
    .seqIndex  (seqIndex)
  );

  function automatic logic [2:0] toGray(input logic [2:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic checkGray(input string req);
    checks++;
    if (grayState !== toGray(refIdx)) begin
      errors++;
      $display("FAIL %s: grayState actual %b expected %b", req, grayState, toGray(refIdx));
    end
    checks++;
    if (seqIndex !== refIdx) begin
      errors++;
      $display("FAIL R5: seqIndex actual %b expected %b", seqIndex, refIdx);
    end
  endtask

  // Drives inputs at the falling edge, lets one rising edge pass,
  // then checks at the next falling edge.
  task automatic cycle(input logic rst, input logic en, input string req);
    logic [2:0] prevGray;
    prevGray = grayState;
    rstSync = rst;
    countEn = en;
    @(posedge clk);
    @(negedge clk);
    if (rst) refIdx = 3'd0;
    else if (en) refIdx = refIdx + 3'd1;
    checkGray(req);
    if (!rst && en) begin
      checks++;
      if ($countones(grayState ^ prevGray) != 1) begin
        errors++;
        $display("FAIL R4: bits changed actual %0d expected 1",
                 $countones(grayState ^ prevGray));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] startGray;
    void'($urandom(32'd2718));
    @(negedge clk);
    cycle(1'b1, 1'b0, "R1");
    cycle(1'b1, 1'b0, "R1");
    // R2 and R6: a full enabled lap, including the step from 100 back to 000.
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, (i == 7) ? "R6" : "R2");
    // R3: hold while disabled.
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, "R3");
    cycle(1'b0, 1'b1, "R2");
    cycle(1'b0, 1'b1, "R2");
    // R7: reset together with enable.
    cycle(1'b1, 1'b1, "R7");
    // R8: eight enabled steps with idle cycles mixed in.
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, "R2");
    startGray = grayState;
    for (int n = 0; n < 8; ) begin
      logic en;
      en = 1'($urandom_range(0, 1));
      cycle(1'b0, en, en ? "R2" : "R3");
      if (en) n++;
    end
    checks++;
    if (grayState !== startGray) begin
      errors++;
      $display("FAIL R8: after eight steps actual %b expected %b", grayState, startGray);
    end
    // Random mix of reset, enable and idle cycles.
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 5)       cycle(1'b1, 1'($urandom_range(0, 1)), "R7");
      else if (r < 70) cycle(1'b0, 1'b1, "R2");
      else             cycle(1'b0, 1'b0, "R3");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule